// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block sits beside the datapath of a 16550-style serial port and turns its live status into one interrupt request line and a 4-bit identifier code. It watches the receive and transmit FIFO fill counts, a pulse for any received line error, a pulse for a receive character timeout, and a pulse for a modem input change. It latches the event-type sources, compares the FIFO counts against the selected trigger levels, and reports only the most urgent enabled source.

Software reads the identifier to find out why the port interrupted. It then services that source, and the service action retires it. A status register read retires a line error. Draining the receive FIFO below its trigger retires the receive source. A data read retires a timeout. A modem status read retires a modem change. A data write retires transmit-empty, and so does an identifier read that reported it. The enable byte and the FIFO control byte come from the register file. This block only reads the fields listed below and ignores every other bit of both bytes.

Top module: `uart_irq_ident`

## Requirements
- R1: While rst_ni is low and after reset, irq_o is 0 and iid_o is 0x1 until some enabled source becomes pending.
- R2: iid_o only ever takes these values: 0x6 for line status, 0xC for receive timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when nothing is pending. In int_en_i, bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status, and bit 7 selects the programmable transmit-empty mode.
- R3: Sources are ranked line status, then receive (timeout or data), then transmit empty, then modem status. iid_o reports only the highest enabled pending source.
- R4: With FIFOs on (fifo_ctl_i bit 0 = 1), the receive source is pending while rx_count_i is at or above the level picked by fifo_ctl_i[7:6]. For DEPTH 16 the levels are: 0 → 1, 1 → DEPTH/4 = 4, 2 → DEPTH/2 = 8, 3 → DEPTH-2 = 14.
- R5: With FIFOs off, the trigger fields are ignored. The receive source is pending when rx_count_i ≥ 1. The transmit condition is tx_count_i = 0, even when bit 7 of int_en_i is set.
- R6: With FIFOs on and bit 7 of int_en_i set, the transmit condition is tx_count_i at or below the level picked by fifo_ctl_i[5:4]: 0 → 0, 1 → 2, 2 → DEPTH/4 = 4, 3 → DEPTH/2 = 8. Otherwise the condition is tx_count_i = 0.
- R7: Transmit-empty becomes pending on the cycle the transmit condition goes from false to true. It clears on data_wr_i, or on iir_rd_i while iid_o shows 0x2. It fires again only on the next false-to-true change.
- R8: A line_err_i pulse latches the line source. It stays pending until lsr_rd_i.
- R9: An rx_tout_i pulse latches the timeout, which is reported as 0xC even when the receive count also meets the trigger. It clears on data_rd_i.
- R10: A modem_chg_i pulse latches the modem source. It stays pending until msr_rd_i.
- R11: irq_o is registered and is 1 exactly when iid_o is not 0x1. Both outputs follow the pending state with one register stage.
- R12: Clearing an enable bit hides its source from irq_o and iid_o but does not discard a latched event. Setting the bit again reports the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_en_i | input | 8 | Enable byte: bit0 rx, bit1 tx, bit2 line, bit3 modem, bit7 programmable tx mode |
| fifo_ctl_i | input | 8 | Stored FIFO control: bit0 FIFO on, [5:4] tx trigger, [7:6] rx trigger |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| tx_count_i | input | CNT_W | Transmit FIFO fill count (holding register when FIFO off) |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break seen |
| rx_tout_i | input | 1 | Pulse: receive character timeout |
| modem_chg_i | input | 1 | Pulse: modem input changed |
| lsr_rd_i | input | 1 | Line status register read |
| msr_rd_i | input | 1 | Modem status register read |
| iir_rd_i | input | 1 | Identifier register read |
| data_rd_i | input | 1 | Receive data read |
| data_wr_i | input | 1 | Transmit data write |
| irq_o | output | 1 | Registered interrupt request |
| iid_o | output | 4 | Registered identifier code |

## Verification
A count change on rx_count_i reaches iid_o at the first rising edge after it is driven. A latched source takes one more edge, because the event is first captured in its latch. This applies to event pulses, clearing reads and writes, and transmit-empty arming on tx_count_i or fifo_ctl_i changes. The driver changes inputs only at falling edges. It waits exactly that number of rising edges before it queues the expected pair, and the monitor compares that pair at the next falling edge. Clearing actions are checked the same way, so a source that is retired too early or too late shows up as a mismatch at that exact cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_TX    = 4'h2,
    IID_RX    = 4'h4,
    IID_LINE  = 4'h6,
    IID_TOUT  = 4'hC
  } iid_e;

  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_TX    = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;
  localparam int unsigned EN_PTX   = 7;

  localparam int unsigned FC_ON    = 0;
  localparam int unsigned FC_TXT   = 4;
  localparam int unsigned FC_RXT   = 6;

  typedef struct packed {
    logic line;
    logic tout;
    logic rx;
    logic tx;
    logic modem;
  } src_t;
endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             fifo_on_i,
  input  logic             ptx_mode_i,
  input  logic [1:0]       rx_trig_i,
  input  logic [1:0]       tx_trig_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic             rx_hit_o,
  output logic             tx_cond_o
);
  logic [CNT_W-1:0] rx_lvl [4];
  logic [CNT_W-1:0] tx_lvl [4];

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    localparam int unsigned RXL = (g == 0) ? 1 : (g == 1) ? DEPTH/4 :
                                  (g == 2) ? DEPTH/2 : DEPTH-2;
    localparam int unsigned TXL = (g == 0) ? 0 : (g == 1) ? 2 :
                                  (g == 2) ? DEPTH/4 : DEPTH/2;
    assign rx_lvl[g] = CNT_W'(RXL);
    assign tx_lvl[g] = CNT_W'(TXL);
  end

  always_comb begin
    if (fifo_on_i) rx_hit_o = (rx_count_i >= rx_lvl[rx_trig_i]);
    else           rx_hit_o = (rx_count_i != '0);
    // threshold mode needs both FIFO and programmable mode
    if (fifo_on_i && ptx_mode_i) tx_cond_o = (tx_count_i <= tx_lvl[tx_trig_i]);
    else                         tx_cond_o = (tx_count_i == '0);
  end
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_err_i,
  input  logic lsr_rd_i,
  input  logic rx_tout_i,
  input  logic data_rd_i,
  input  logic modem_chg_i,
  input  logic msr_rd_i,
  input  logic tx_cond_i,
  input  logic tx_ack_i,
  input  logic data_wr_i,
  output logic line_o,
  output logic tout_o,
  output logic modem_o,
  output logic tx_o
);
  localparam int unsigned N_STICKY = 3;

  logic [N_STICKY-1:0] set_v, clr_v, q_v;
  logic tx_cond_q, tx_q;

  assign set_v = {modem_chg_i, rx_tout_i, line_err_i};
  assign clr_v = {msr_rd_i,    data_rd_i, lsr_rd_i};

  // event latches: a new event wins over a same-cycle clear
  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_v[g] <= 1'b0;
      else if (set_v[g]) q_v[g] <= 1'b1;
      else if (clr_v[g]) q_v[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cond_q <= 1'b0;
      tx_q      <= 1'b0;
    end else begin
      tx_cond_q <= tx_cond_i;
      if (tx_ack_i || data_wr_i)      tx_q <= 1'b0;
      else if (tx_cond_i && !tx_cond_q) tx_q <= 1'b1;
    end
  end

  assign line_o  = q_v[0];
  assign tout_o  = q_v[1];
  assign modem_o = q_v[2];
  assign tx_o    = tx_q;

  p_wr_clears_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> !tx_o);
  p_modem_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modem_chg_i |=> modem_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_t src_i,
  output iid_e iid_o,
  output logic any_o
);
  always_comb begin
    if      (src_i.line)  iid_o = IID_LINE;
    else if (src_i.tout)  iid_o = IID_TOUT;
    else if (src_i.rx)    iid_o = IID_RX;
    else if (src_i.tx)    iid_o = IID_TX;
    else if (src_i.modem) iid_o = IID_MODEM;
    else                  iid_o = IID_NONE;
  end
  assign any_o = |src_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       int_en_i,
  input  logic [7:0]       fifo_ctl_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             line_err_i,
  input  logic             rx_tout_i,
  input  logic             modem_chg_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             iir_rd_i,
  input  logic             data_rd_i,
  input  logic             data_wr_i,
  output logic             irq_o,
  output logic [3:0]       iid_o
);
  logic rx_hit, tx_cond, tx_ack;
  logic line_p, tout_p, modem_p, tx_p;
  src_t src;
  iid_e iid_d;
  logic any_d;

  uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .fifo_on_i (fifo_ctl_i[FC_ON]),
    .ptx_mode_i(int_en_i[EN_PTX]),
    .rx_trig_i (fifo_ctl_i[FC_RXT +: 2]),
    .tx_trig_i (fifo_ctl_i[FC_TXT +: 2]),
    .rx_count_i(rx_count_i),
    .tx_count_i(tx_count_i),
    .rx_hit_o  (rx_hit),
    .tx_cond_o (tx_cond)
  );

  // an identifier read acknowledges transmit-empty only if it showed it
  assign tx_ack = iir_rd_i && (iid_o == IID_TX);

  uart_irq_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_err_i (line_err_i),
    .lsr_rd_i   (lsr_rd_i),
    .rx_tout_i  (rx_tout_i),
    .data_rd_i  (data_rd_i),
    .modem_chg_i(modem_chg_i),
    .msr_rd_i   (msr_rd_i),
    .tx_cond_i  (tx_cond),
    .tx_ack_i   (tx_ack),
    .data_wr_i  (data_wr_i),
    .line_o     (line_p),
    .tout_o     (tout_p),
    .modem_o    (modem_p),
    .tx_o       (tx_p)
  );

  assign src.line  = line_p  & int_en_i[EN_LINE];
  assign src.tout  = tout_p  & int_en_i[EN_RX];
  assign src.rx    = rx_hit  & int_en_i[EN_RX];
  assign src.tx    = tx_p    & int_en_i[EN_TX];
  assign src.modem = modem_p & int_en_i[EN_MODEM];

  uart_irq_prio u_prio (
    .src_i(src),
    .iid_o(iid_d),
    .any_o(any_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      iid_o <= IID_NONE;
    end else begin
      irq_o <= any_d;
      iid_o <= iid_d;
    end
  end

  p_irq_matches_id_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o != IID_NONE));
  p_iid_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o inside {IID_MODEM, IID_NONE, IID_TX, IID_RX, IID_LINE, IID_TOUT});
  p_line_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_p && int_en_i[EN_LINE]) |=> (iid_o == IID_LINE));
  p_tout_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_p && int_en_i[EN_RX] && !(line_p && int_en_i[EN_LINE])) |=> (iid_o == IID_TOUT));
  p_lsr_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !line_err_i) |=> !line_p);
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  typedef struct {
    logic       irq;
    logic [3:0] iid;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] int_en = 8'h00, fifo_ctl = 8'h00;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic line_err = 0, rx_tout = 0, modem_chg = 0;
  logic lsr_rd = 0, msr_rd = 0, iir_rd = 0, data_rd = 0, data_wr = 0;
  logic irq;
  logic [3:0] iid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  uart_irq_ident #(.DEPTH(DEPTH)) u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_ni), .int_en_i(int_en), .fifo_ctl_i(fifo_ctl),
    .rx_count_i(rx_count), .tx_count_i(tx_count),
    .line_err_i(line_err), .rx_tout_i(rx_tout), .modem_chg_i(modem_chg),
    .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .iir_rd_i(iir_rd),
    .data_rd_i(data_rd), .data_wr_i(data_wr),
    .irq_o(irq), .iid_o(iid)
  );

  // monitor: compares queued expectations at falling edges
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (irq !== e.irq || iid !== e.iid) begin
        n_bad++;
        $display("FAIL %s: irq=%0b iid=0x%h expected irq=%0b iid=0x%h",
                 e.tag, irq, iid, e.irq, e.iid);
      end
    end
  end

  // wait n rising edges, queue the expected pair, return at the next falling edge
  task automatic expect_out(input int n, input logic e_irq, input logic [3:0] e_iid,
                            input string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    #1;
    e.irq = e_irq; e.iid = e_iid; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // one-cycle strobe: 0 line,1 tout,2 modem,3 lsr,4 msr,5 iir,6 drd,7 dwr
  task automatic pulse(input int sel);
    case (sel)
      0: line_err = 1; 1: rx_tout = 1; 2: modem_chg = 1; 3: lsr_rd = 1;
      4: msr_rd = 1;   5: iir_rd = 1;  6: data_rd = 1;   default: data_wr = 1;
    endcase
    @(negedge clk);
    {line_err, rx_tout, modem_chg, lsr_rd, msr_rd, iir_rd, data_rd, data_wr} = '0;
  endtask

  initial begin
    expect_out(2, 0, 4'h1, "R1 in reset");
    rst_ni = 1'b1;
    expect_out(2, 0, 4'h1, "R1 after reset, tx masked");

    // R12 / R5: enabling tx reveals latched holding-empty, FIFO off
    int_en = 8'h02;
    expect_out(1, 1, 4'h2, "R5 holding empty");
    pulse(5);
    expect_out(1, 0, 4'h1, "R7 iid read clears tx");
    tx_count = 1;
    expect_out(1, 0, 4'h1, "R7 not empty");
    tx_count = 0;
    expect_out(2, 1, 4'h2, "R7 rearm on empty");
    pulse(7);
    expect_out(1, 0, 4'h1, "R7 data write clears tx");

    // line, rx and modem ranking
    int_en = 8'h0F;
    pulse(0);
    expect_out(1, 1, 4'h6, "R8 line pending");
    rx_count = 1;
    expect_out(1, 1, 4'h6, "R3 line over rx");
    pulse(3);
    expect_out(1, 1, 4'h4, "R8 lsr read clears, R5 one byte");
    pulse(2);
    expect_out(1, 1, 4'h4, "R3 rx over modem");
    rx_count = 0;
    expect_out(1, 1, 4'h0, "R10 modem reported");
    pulse(4);
    expect_out(1, 0, 4'h1, "R10 msr read clears");

    // R4 receive trigger levels with FIFO on
    fifo_ctl = 8'h81; rx_count = 7;
    expect_out(1, 0, 4'h1, "R4 half level, 7 below");
    rx_count = 8;
    expect_out(1, 1, 4'h4, "R4 half level reached");
    fifo_ctl = 8'hC1;
    expect_out(1, 0, 4'h1, "R4 full-2 level, 8 below");
    rx_count = 14;
    expect_out(1, 1, 4'h4, "R4 full-2 level reached");
    fifo_ctl = 8'h41; rx_count = 3;
    expect_out(1, 0, 4'h1, "R4 quarter level, 3 below");
    rx_count = 4;
    expect_out(1, 1, 4'h4, "R4 quarter level reached");
    fifo_ctl = 8'h01; rx_count = 1;
    expect_out(1, 1, 4'h4, "R4 one-byte level");
    fifo_ctl = 8'hC0; rx_count = 1;
    expect_out(1, 1, 4'h4, "R5 FIFO off ignores rx trigger");

    // R9 timeout
    fifo_ctl = 8'h41; rx_count = 2;
    expect_out(1, 0, 4'h1, "R9 below trigger");
    pulse(1);
    expect_out(1, 1, 4'hC, "R9 timeout code");
    pulse(6);
    expect_out(1, 0, 4'h1, "R9 data read clears");
    rx_count = 4;
    pulse(1);
    expect_out(1, 1, 4'hC, "R9 timeout over threshold code");
    pulse(6);
    expect_out(1, 1, 4'h4, "R9 back to threshold code");
    rx_count = 0;
    expect_out(1, 0, 4'h1, "R4 drained");

    // R6 programmable transmit mode
    int_en = 8'h8F; fifo_ctl = 8'h21; tx_count = 5;
    expect_out(1, 0, 4'h1, "R6 5 above level 4");
    tx_count = 4;
    expect_out(2, 1, 4'h2, "R6 at level 4");
    pulse(5);
    expect_out(1, 0, 4'h1, "R7 iid read clears");
    fifo_ctl = 8'h31;
    expect_out(2, 0, 4'h1, "R7 no rearm without fresh rise");
    tx_count = 9;
    expect_out(1, 0, 4'h1, "R6 9 above level 8");
    tx_count = 8;
    expect_out(2, 1, 4'h2, "R6 at level 8");
    pulse(7);
    expect_out(1, 0, 4'h1, "R7 write clears");
    fifo_ctl = 8'h11; tx_count = 3;
    expect_out(2, 0, 4'h1, "R6 3 above level 2");
    tx_count = 2;
    expect_out(2, 1, 4'h2, "R6 at level 2");
    pulse(5);
    expect_out(1, 0, 4'h1, "R7 iid read clears");
    fifo_ctl = 8'h10;
    expect_out(2, 0, 4'h1, "R5 FIFO off needs empty");
    tx_count = 0;
    expect_out(2, 1, 4'h2, "R5 holding empty with mode bit set");
    pulse(7);
    expect_out(1, 0, 4'h1, "R7 write clears");

    // R12 masked line event survives
    int_en = 8'h8B;
    pulse(0);
    expect_out(1, 0, 4'h1, "R12 masked line hidden");
    int_en = 8'h8F;
    expect_out(1, 1, 4'h6, "R12 line revealed");
    pulse(2);
    pulse(3);
    expect_out(1, 1, 4'h0, "R3 modem after line cleared");
    pulse(4);
    expect_out(1, 0, 4'h1, "R11 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule